// File: doc/BRIEF.md
# Operating-Mode Memory Access Decoder

This block classifies every access on a 16-bit CPU address bus and steers it to one of three targets: the on-chip RAM and register file, the on-chip ROM, or the external memory bus. Two inputs set the routing. A board-level strap pin decides whether the top 8 KB window is served by internal ROM or by external memory. A software-controlled status bit decides whether the rest of the 64 KB map is open or restricted. In restricted mode, accesses outside the on-chip ranges are blocked and reported as illegal-address events to the watchdog.

The external bus width is captured from the high-byte-enable pin while reset is held, and it stays fixed until the next reset. On a 16-bit bus the block drives a high-byte enable for external accesses that touch the upper byte lane. On an 8-bit bus that enable stays low.

All outputs come from registers. They show the decision for the access that was presented on the previous clock edge.

Top module: `opmode_mem_decoder`

## Requirements
- R1: An access to 0x0000–0x01FF asserts `ram_sel_o` one cycle later, whatever the strap pin and status bit are, and never raises `illegal_addr_o`.
- R2: An access to 0xE000–0xFFFF with `rom_bypass_i` = 0 asserts `rom_sel_o` one cycle later and produces no external strobe.
- R3: An access to 0xE000–0xFFFF with `rom_bypass_i` = 1 is sent to the external bus (a read or write strobe one cycle later) and never asserts `rom_sel_o`.
- R4: With `wide_map_i` = 0, an access to 0x0200–0xDFFF is blocked. No select and no strobe is produced, and `illegal_addr_o` is high for exactly the one cycle after that access.
- R5: With `wide_map_i` = 1, an access to 0x0200–0xDFFF is sent to the external bus, and `illegal_addr_o` never rises.
- R6: `ext_rd_o` follows only external reads (`acc_we_i` = 0) and `ext_wr_o` follows only external writes (`acc_we_i` = 1). Internal and blocked accesses produce neither strobe.
- R7: Every output is registered and reflects the access presented on the previous rising edge. A cycle with `acc_valid_i` = 0 gives all outputs low in the following cycle, and at most one of RAM select, ROM select, external strobe and illegal flag is high at any time.
- R8: A high level on `hbe_pin_i` while reset is applied selects the 8-bit bus, and a low level selects the 16-bit bus. The choice holds until the next reset, and later changes on `hbe_pin_i` have no effect on `hbe_o`.
- R9: On a 16-bit bus, `hbe_o` is high for an external access that is a word access (`acc_word_i` = 1) or a byte access to an odd address (bit 0 = 1). It is low for even-address byte accesses and for every non-external access.
- R10: On an 8-bit bus, `hbe_o` is always low.
- R11: While reset is applied, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rom_bypass_i | input | 1 | Strap: 1 sends the top ROM window to external memory |
| wide_map_i | input | 1 | Status bit: 1 opens the full 64 KB map and disables illegal-address detection |
| hbe_pin_i | input | 1 | High-byte-enable pin level, sampled during reset for the bus width |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_word_i | input | 1 | 1 = 16-bit word access, 0 = byte access |
| acc_addr_i | input | 16 | Byte address of the access |
| ram_sel_o | output | 1 | Internal RAM/register select |
| rom_sel_o | output | 1 | Internal ROM select |
| ext_rd_o | output | 1 | External read strobe |
| ext_wr_o | output | 1 | External write strobe |
| hbe_o | output | 1 | High-byte enable for the external bus |
| illegal_addr_o | output | 1 | One-cycle illegal-address pulse to the watchdog |

## Verification
The assertions assume that `hbe_pin_i` is steady during the cycles in which reset is applied and for the two synchronizer cycles after its release. They also assume that the strap pin, the status bit and the access fields are driven clean between clock edges. The stimulus follows both assumptions. It holds the width pin constant throughout each reset window, changes every input only on the falling clock edge, and moves the width pin only once the synchronized reset has been released. Within those limits, the stimulus covers all four mode combinations, the edge addresses of each range, reads and writes, word and byte sizes, and random traffic.

// File: rtl/opmode_mem_pkg.sv
package opmode_mem_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_ROM  = 2'd2,
    TGT_EXT  = 2'd3
  } target_e;

  typedef struct packed {
    logic ram_sel;
    logic rom_sel;
    logic ext_rd;
    logic ext_wr;
    logic hbe;
    logic illegal;
  } route_out_t;

endpackage

// File: rtl/opmode_rst_sync.sv
module opmode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_s_n = chain_q[LAST];

endmodule

// File: rtl/opmode_region_decode.sv
module opmode_region_decode
  import opmode_mem_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RAM_LAST = 16'h01FF,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hE000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_bypass_i,
  input  logic              wide_map_i,
  output target_e           target_o
);

  logic in_ram;
  logic in_rom;

  always_comb begin
    in_ram = (addr_i <= RAM_LAST);
    in_rom = (addr_i >= ROM_BASE);
  end

  always_comb begin
    if (in_ram) begin
      target_o = TGT_RAM;
    end else if (in_rom) begin
      target_o = rom_bypass_i ? TGT_EXT : TGT_ROM;
    end else if (wide_map_i) begin
      target_o = TGT_EXT;
    end else begin
      target_o = TGT_NONE;
    end
  end

endmodule

// File: rtl/opmode_width_latch.sv
module opmode_width_latch (
  input  logic clk,
  input  logic rst_s_n,
  input  logic hbe_pin_i,
  output logic bus8_o
);

  logic bus8_q;
  logic bus8_d;
  logic load_en;
  logic armed_q;

  always_comb begin
    load_en = !rst_s_n;
    bus8_d  = hbe_pin_i;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      bus8_q <= bus8_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  assign bus8_o = bus8_q;

  // R8: width choice frozen while out of reset
  p_width_held_r8: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    $stable(bus8_q));

endmodule

// File: rtl/opmode_access_router.sv
module opmode_access_router
  import opmode_mem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic              acc_word_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              wide_map_i,
  input  target_e           target_i,
  input  logic              bus8_i,
  output route_out_t        route_o
);

  route_out_t route_d;
  route_out_t route_q;
  logic       armed_q;
  logic       is_ext;
  logic       upper_lane;

  always_comb begin
    is_ext     = acc_valid_i && (target_i == TGT_EXT);
    upper_lane = acc_word_i || acc_addr_i[0];
    route_d    = '0;
    if (acc_valid_i) begin
      unique case (target_i)
        TGT_RAM:  route_d.ram_sel = 1'b1;
        TGT_ROM:  route_d.rom_sel = 1'b1;
        TGT_EXT: begin
          route_d.ext_rd = !acc_we_i;
          route_d.ext_wr = acc_we_i;
        end
        default:  route_d.illegal = 1'b1;
      endcase
    end
    route_d.hbe = is_ext && !bus8_i && upper_lane;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      route_q <= '0;
    end else begin
      route_q <= route_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  assign route_o = route_q;

  // R7: at most one destination per cycle
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    $onehot0({route_q.ram_sel, route_q.rom_sel, route_q.ext_rd | route_q.ext_wr, route_q.illegal}));

  // R6: read strobe only after a read access
  p_rd_from_read_r6: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    route_q.ext_rd |-> $past(acc_valid_i && !acc_we_i));

  // R6: write strobe only after a write access
  p_wr_from_write_r6: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    route_q.ext_wr |-> $past(acc_valid_i && acc_we_i));

  // R4: illegal pulse only under restricted map
  p_illegal_narrow_r4: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    route_q.illegal |-> $past(!wide_map_i));

  // R1: low range is always served on-chip
  p_ram_onchip_r1: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    (acc_valid_i && (acc_addr_i <= 16'h01FF)) |=> route_q.ram_sel);

  // R9: high-byte enable only with an external strobe
  p_hbe_ext_r9: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    route_q.hbe |-> (route_q.ext_rd || route_q.ext_wr));

  // R10: narrow bus never uses the upper lane
  p_bus8_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s_n || !armed_q)
    bus8_i |-> !route_q.hbe);

endmodule

// File: rtl/opmode_mem_decoder.sv
module opmode_mem_decoder
  import opmode_mem_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] RAM_LAST    = 16'h01FF,
  parameter logic [ADDR_W-1:0] ROM_BASE    = 16'hE000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_bypass_i,
  input  logic              wide_map_i,
  input  logic              hbe_pin_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic              acc_word_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              ram_sel_o,
  output logic              rom_sel_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic              hbe_o,
  output logic              illegal_addr_o
);

  logic       rst_s_n;
  logic       bus8;
  target_e    target;
  route_out_t route;

  opmode_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  opmode_width_latch u_width (
    .clk       (clk),
    .rst_s_n   (rst_s_n),
    .hbe_pin_i (hbe_pin_i),
    .bus8_o    (bus8)
  );

  opmode_region_decode #(
    .ADDR_W   (ADDR_W),
    .RAM_LAST (RAM_LAST),
    .ROM_BASE (ROM_BASE)
  ) u_decode (
    .addr_i       (acc_addr_i),
    .rom_bypass_i (rom_bypass_i),
    .wide_map_i   (wide_map_i),
    .target_o     (target)
  );

  opmode_access_router #(.ADDR_W(ADDR_W)) u_router (
    .clk         (clk),
    .rst_s_n     (rst_s_n),
    .acc_valid_i (acc_valid_i),
    .acc_we_i    (acc_we_i),
    .acc_word_i  (acc_word_i),
    .acc_addr_i  (acc_addr_i),
    .wide_map_i  (wide_map_i),
    .target_i    (target),
    .bus8_i      (bus8),
    .route_o     (route)
  );

  assign ram_sel_o      = route.ram_sel;
  assign rom_sel_o      = route.rom_sel;
  assign ext_rd_o       = route.ext_rd;
  assign ext_wr_o       = route.ext_wr;
  assign hbe_o          = route.hbe;
  assign illegal_addr_o = route.illegal;

endmodule

// File: tb/tb_opmode_mem_decoder.sv
module tb_opmode_mem_decoder;

  logic        clk;
  logic        rst_n;
  logic        rom_bypass_i;
  logic        wide_map_i;
  logic        hbe_pin_i;
  logic        acc_valid_i;
  logic        acc_we_i;
  logic        acc_word_i;
  logic [15:0] acc_addr_i;
  logic        ram_sel_o;
  logic        rom_sel_o;
  logic        ext_rd_o;
  logic        ext_wr_o;
  logic        hbe_o;
  logic        illegal_addr_o;

  int checks;
  int fails;
  bit bus8_exp;
  logic [5:0] exp_q;
  string tag_q;

  opmode_mem_decoder dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rom_bypass_i   (rom_bypass_i),
    .wide_map_i     (wide_map_i),
    .hbe_pin_i      (hbe_pin_i),
    .acc_valid_i    (acc_valid_i),
    .acc_we_i       (acc_we_i),
    .acc_word_i     (acc_word_i),
    .acc_addr_i     (acc_addr_i),
    .ram_sel_o      (ram_sel_o),
    .rom_sel_o      (rom_sel_o),
    .ext_rd_o       (ext_rd_o),
    .ext_wr_o       (ext_wr_o),
    .hbe_o          (hbe_o),
    .illegal_addr_o (illegal_addr_o)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [5:0] outs();
    return {ram_sel_o, rom_sel_o, ext_rd_o, ext_wr_o, hbe_o, illegal_addr_o};
  endfunction

  // Reference model: {ram, rom, rd, wr, hbe, illegal}
  function automatic logic [5:0] model(input bit v, input bit we, input bit wd,
                                       input logic [15:0] a, input bit byp,
                                       input bit wide, input bit b8);
    bit ram, rom, ext, ill, hb;
    ram = 0; rom = 0; ext = 0; ill = 0; hb = 0;
    if (v) begin
      if (a < 16'h0200) ram = 1;                       // R1
      else if (a >= 16'hE000) begin
        if (byp) ext = 1; else rom = 1;                // R2 R3
      end else if (wide) ext = 1;                      // R5
      else ill = 1;                                    // R4
    end
    if (ext && !b8 && (wd || a[0])) hb = 1;            // R9 R10
    return {ram, rom, ext && !we, ext && we, hb, ill}; // R6
  endfunction

  function automatic string tag_for(input bit v, input logic [15:0] a,
                                    input bit byp, input bit wide, input bit b8);
    string t;
    if (!v) t = "R7";
    else if (a < 16'h0200) t = "R1";
    else if (a >= 16'hE000) t = byp ? "R3 R6" : "R2";
    else t = wide ? "R5 R6" : "R4";
    t = {t, b8 ? " R8 R10" : " R8 R9"};
    return t;
  endfunction

  task automatic compare();
    checks++;
    if (outs() !== exp_q) begin
      fails++;
      $display("FAIL %s: got %b expected %b (ram rom rd wr hbe ill)", tag_q, outs(), exp_q);
    end
  endtask

  task automatic step(input bit v, input bit we, input bit wd, input logic [15:0] a,
                      input bit byp, input bit wide, input bit pin);
    @(negedge clk);
    compare();
    acc_valid_i  = v;
    acc_we_i     = we;
    acc_word_i   = wd;
    acc_addr_i   = a;
    rom_bypass_i = byp;
    wide_map_i   = wide;
    hbe_pin_i    = pin;
    exp_q = model(v, we, wd, a, byp, wide, bus8_exp);
    tag_q = tag_for(v, a, byp, wide, bus8_exp);
  endtask

  task automatic do_reset(input bit pin);
    @(negedge clk);
    rst_n = 1'b0;
    acc_valid_i = 0; acc_we_i = 0; acc_word_i = 0; acc_addr_i = '0;
    rom_bypass_i = 0; wide_map_i = 0; hbe_pin_i = pin;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checks++;
      if (outs() !== 6'b0) begin
        fails++;
        $display("FAIL R11: got %b expected %b during reset", outs(), 6'b0);
      end
    end
    rst_n = 1'b1;
    bus8_exp = pin;
    exp_q = '0;
    tag_q = "R7 R11";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 16'h0000, 0, 0, pin);
  endtask

  task automatic run_phase(input bit pin);
    logic [15:0] corners [8];
    corners = '{16'h0000, 16'h01FF, 16'h0200, 16'h1235,
                16'hDFFF, 16'hE000, 16'hE001, 16'hFFFF};
    do_reset(pin);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        for (int t = 0; t < 4; t++) begin
          step(1, t[0], t[1], corners[k], m[0], m[1], pin);
          if (k == 3 && t == 0) step(0, 0, 0, corners[k], m[0], m[1], pin);
        end
    // R8: width pin moves after reset, must have no effect
    for (int n = 0; n < 1500; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
           16'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    step(0, 0, 0, 16'h0000, 0, 0, 0);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    exp_q = '0;
    tag_q = "R11";
    run_phase(1'b1);   // 8-bit bus
    run_phase(1'b0);   // 16-bit bus
    run_phase(1'b1);   // back to 8-bit after a fresh reset
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule